// File: doc/BRIEF.md
# Display List Playfield Fetcher

This block walks a list of one-byte band instructions held in memory and turns each one into a description of a horizontal band of the screen. A band is either a run of blank scan lines or a graphics band in one of fourteen modes. Each mode has a fixed height in scan lines. The block reports every band on a valid/ready output stream, tracks which band is current on each scan line, and raises an interrupt pulse on the last scan line of any band whose instruction asks for one.

Software sets the block up through three write-only byte registers: a control byte, and the low and high bytes of a 16-bit list pointer. None of them can be read back. A `frame_start` pulse copies the pointer into the fetch address. After that, each `line_start` pulse either moves the current band on by one scan line, or, when the band has no lines left, fetches the next instruction over a request/grant memory port. Fetching and band tracking run only while list DMA is enabled and the playfield width is nonzero.

The output stream carries one record per fetched instruction. The record stays on the stream until it is accepted. While the stream has a record waiting, the next memory request is held off, so a slow consumer delays the fetch rather than losing a band.

Top module: `dl_fetcher`

## Requirements
- R1: A write to select 0 stores the control byte. Bits [1:0] select the width: 0 gives `pf_clocks`=0, 1 gives 128, 2 gives 160 and 3 gives 192. `pf_enable` is high only when bit 5 is set and the width field is nonzero.
- R2: While `pf_enable` is low, `line_start` pulses start no memory request and produce no band.
- R3: Select 1 writes the low byte of the list pointer and select 2 writes the high byte. `frame_start` loads the pointer into the fetch address. Pointer writes made after `frame_start` do not change the fetches of that frame.
- R4: Once `mem_req` is raised, it stays high with `mem_addr` unchanged until `mem_gnt`. The byte on `mem_rdata` is taken in the cycle of the grant. Each fetch advances the address by one, and the address wraps modulo 2^16.
- R5: A `line_start` fetches exactly one new instruction only when the current band has no lines left. Otherwise it uses one line of the current band. `line_mode` shows the current band's mode and `line_active` stays high while a band is current.
- R6: An instruction byte with low nibble 0 gives a blank band (`band_mode`=0) of bits[6:4]+1 lines. Low nibble 1 gives a single blank line. Blank bands never carry scroll flags.
- R7: For low nibble 2 to F, `band_mode` equals the nibble and the height in lines is: 2→8, 3→10, 4→8, 5→16, 6→8, 7→16, 8→8, 9→4, A→4, B→2, C→1, D→2, E→1, F→1.
- R8: For graphics bands, bit 4 sets `band_hscroll` and bit 5 sets `band_vscroll`. Bit 7 sets `band_irq` for any instruction.
- R9: For an instruction with bit 7 set, `irq_pulse` is high for exactly one cycle. For a one-line band this is the cycle after the fetch grant. Otherwise it is the cycle after the `line_start` that begins the band's last line.
- R10: A band record stays valid with all fields unchanged until `band_ready`. Each fetched instruction is delivered exactly once, and no new fetch is requested while a record waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 pointer low, 2 pointer high |
| cfg_wdata | input | 8 | Register write data |
| frame_start | input | 1 | Restart the list at the stored pointer |
| line_start | input | 1 | Start of a scan line |
| mem_req | output | 1 | Instruction fetch request |
| mem_addr | output | 16 | Fetch address |
| mem_gnt | input | 1 | Fetch grant, data valid this cycle |
| mem_rdata | input | 8 | Fetched instruction byte |
| band_valid | output | 1 | Band record valid |
| band_ready | input | 1 | Consumer accepts band record |
| band_mode | output | 4 | Band mode, 0 for blank |
| band_lines | output | 5 | Band height in scan lines |
| band_hscroll | output | 1 | Horizontal fine scroll enabled |
| band_vscroll | output | 1 | Vertical fine scroll enabled |
| band_irq | output | 1 | Band requests an interrupt |
| line_active | output | 1 | A band is current on this line |
| line_mode | output | 4 | Mode of the current band |
| irq_pulse | output | 1 | One-cycle interrupt on a band's last line |
| pf_enable | output | 1 | Playfield enabled |
| pf_clocks | output | 8 | Playfield width in colour clocks |

## Verification
The assertions assume that the memory side does not raise `mem_gnt` in a cycle where `mem_req` is low. They also assume that `frame_start` and `line_start` are single-cycle pulses, spaced far enough apart that each fetch finishes and its record is accepted before the next line begins. The stimulus keeps to these assumptions. The memory model grants only against a live request, after a random delay of zero to three cycles. Each scan line is a fixed twenty-cycle window in which `band_ready` toggles at random at first and is then forced high, so the stalls are real but always end within the line. Instruction bytes come from seeded random lists, plus a directed list that covers every mode, both blank forms and the interrupt flag, and a list placed just below the top of the address space so that the fetch address wraps.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

  typedef enum logic [0:0] {
    SQ_WAIT  = 1'b0,
    SQ_FETCH = 1'b1
  } sq_state_t;

  typedef struct packed {
    logic [3:0] mode;
    logic [4:0] lines;
    logic       hscr;
    logic       vscr;
    logic       irq;
  } band_t;

  // Height in scan lines of each graphics mode.
  function automatic logic [4:0] mode_height(input logic [3:0] m);
    logic [4:0] h;
    case (m)
      4'h3:               h = 5'd10;
      4'h5, 4'h7:         h = 5'd16;
      4'h9, 4'hA:         h = 5'd4;
      4'hB, 4'hD:         h = 5'd2;
      4'hC, 4'hE, 4'hF:   h = 5'd1;
      default:            h = 5'd8;
    endcase
    return h;
  endfunction

  function automatic logic [7:0] width_clocks(input logic [1:0] w);
    logic [7:0] c;
    case (w)
      2'd1:    c = 8'd128;
      2'd2:    c = 8'd160;
      2'd3:    c = 8'd192;
      default: c = 8'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dlf_cfg_regs.sv
module dlf_cfg_regs
  import dlf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] list_ptr,
  output logic              pf_on,
  output logic [7:0]        pf_clocks
);

  localparam int NBYTES = ADDR_W / 8;

  logic [1:0] width_q;
  logic       dma_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= '0;
      dma_q   <= 1'b0;
    end else if (wr_en && wr_sel == '0) begin
      width_q <= wr_data[1:0];
      dma_q   <= wr_data[5];
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_ptr
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q <= '0;
      else if (wr_en && wr_sel == SEL_W'(g + 1))
        byte_q <= wr_data;
    end
    assign list_ptr[8*g +: 8] = byte_q;
  end

  assign pf_on     = dma_q && (width_q != 2'd0);
  assign pf_clocks = width_clocks(width_q);

endmodule

// File: rtl/dlf_decode.sv
module dlf_decode
  import dlf_pkg::*;
(
  input  logic [7:0] instr,
  output band_t      band
);

  logic [3:0] nib;
  assign nib = instr[3:0];

  always_comb begin
    band.irq = instr[7];
    if (nib == 4'h0) begin
      band.mode  = 4'h0;
      band.lines = {2'b00, instr[6:4]} + 5'd1;
      band.hscr  = 1'b0;
      band.vscr  = 1'b0;
    end else if (nib == 4'h1) begin
      band.mode  = 4'h0;
      band.lines = 5'd1;
      band.hscr  = 1'b0;
      band.vscr  = 1'b0;
    end else begin
      band.mode  = nib;
      band.lines = mode_height(nib);
      band.hscr  = instr[4];
      band.vscr  = instr[5];
    end
  end

endmodule

// File: rtl/dlf_seq.sv
module dlf_seq
  import dlf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_on,
  input  logic [ADDR_W-1:0] list_ptr,
  input  logic              frame_start,
  input  logic              line_start,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  band_t             dec,
  output logic              band_valid,
  input  logic              band_ready,
  output band_t             band_out,
  output logic              line_active,
  output logic [3:0]        line_mode,
  output logic              irq_pulse
);

  sq_state_t         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [4:0]        remain_q;
  logic              cur_irq_q;
  logic              restart_q;
  logic              valid_q;
  band_t             band_q;
  logic              active_q;
  logic [3:0]        lmode_q;
  logic              irq_q;
  logic              fire;

  assign mem_req  = (state_q == SQ_FETCH) && !valid_q;
  assign mem_addr = addr_q;
  assign fire     = mem_req && mem_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_WAIT;
      addr_q    <= '0;
      remain_q  <= '0;
      cur_irq_q <= 1'b0;
      restart_q <= 1'b0;
      valid_q   <= 1'b0;
      band_q    <= '0;
      active_q  <= 1'b0;
      lmode_q   <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (valid_q && band_ready)
        valid_q <= 1'b0;
      case (state_q)
        SQ_WAIT: begin
          if (frame_start) begin
            addr_q    <= list_ptr;
            remain_q  <= '0;
            cur_irq_q <= 1'b0;
            active_q  <= 1'b0;
          end else if (line_start && pf_on) begin
            if (remain_q == '0) begin
              state_q  <= SQ_FETCH;
              active_q <= 1'b0;
            end else begin
              remain_q <= remain_q - 5'd1;
              if (remain_q == 5'd1 && cur_irq_q)
                irq_q <= 1'b1;
            end
          end
        end
        SQ_FETCH: begin
          if (frame_start)
            restart_q <= 1'b1;
          if (fire) begin
            state_q <= SQ_WAIT;
            if (restart_q || frame_start) begin
              addr_q    <= list_ptr;
              remain_q  <= '0;
              cur_irq_q <= 1'b0;
              restart_q <= 1'b0;
              active_q  <= 1'b0;
            end else begin
              addr_q    <= addr_q + 1'b1;
              valid_q   <= 1'b1;
              band_q    <= dec;
              remain_q  <= dec.lines - 5'd1;
              cur_irq_q <= dec.irq;
              irq_q     <= dec.irq && (dec.lines == 5'd1);
              active_q  <= 1'b1;
              lmode_q   <= dec.mode;
            end
          end
        end
        default: state_q <= SQ_WAIT;
      endcase
    end
  end

  assign band_valid  = valid_q;
  assign band_out    = band_q;
  assign line_active = active_q;
  assign line_mode   = lmode_q;
  assign irq_pulse   = irq_q;

endmodule

// File: rtl/dl_fetcher.sv
module dl_fetcher
  import dlf_pkg::*;
#(
  parameter  int ADDR_W = 16,
  localparam int SEL_W  = $clog2(ADDR_W / 8 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic              frame_start,
  input  logic              line_start,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic              band_valid,
  input  logic              band_ready,
  output logic [3:0]        band_mode,
  output logic [4:0]        band_lines,
  output logic              band_hscroll,
  output logic              band_vscroll,
  output logic              band_irq,
  output logic              line_active,
  output logic [3:0]        line_mode,
  output logic              irq_pulse,
  output logic              pf_enable,
  output logic [7:0]        pf_clocks
);

  logic [ADDR_W-1:0] list_ptr;
  logic              pf_on;
  band_t             dec_band;
  band_t             out_band;

  dlf_cfg_regs #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_sel   (cfg_sel),
    .wr_data  (cfg_wdata),
    .list_ptr (list_ptr),
    .pf_on    (pf_on),
    .pf_clocks(pf_clocks)
  );

  dlf_decode u_dec (
    .instr(mem_rdata),
    .band (dec_band)
  );

  dlf_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pf_on      (pf_on),
    .list_ptr   (list_ptr),
    .frame_start(frame_start),
    .line_start (line_start),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .dec        (dec_band),
    .band_valid (band_valid),
    .band_ready (band_ready),
    .band_out   (out_band),
    .line_active(line_active),
    .line_mode  (line_mode),
    .irq_pulse  (irq_pulse)
  );

  assign pf_enable    = pf_on;
  assign band_mode    = out_band.mode;
  assign band_lines   = out_band.lines;
  assign band_hscroll = out_band.hscr;
  assign band_vscroll = out_band.vscr;
  assign band_irq     = out_band.irq;

endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_gnt,
  input logic              band_valid,
  input logic              band_ready,
  input logic [3:0]        band_mode,
  input logic [4:0]        band_lines,
  input logic              band_hscroll,
  input logic              band_vscroll,
  input logic              band_irq,
  input logic              line_active,
  input logic              irq_pulse,
  input logic              pf_enable,
  input logic [7:0]        pf_clocks
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && mem_addr == $past(mem_addr)); // R4

  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    band_valid && !band_ready |=> band_valid &&
      $stable({band_mode, band_lines, band_hscroll, band_vscroll, band_irq})); // R10

  AST_BLANK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    band_valid && band_mode == 4'h0 |-> !band_hscroll && !band_vscroll); // R6

  AST_LINES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    band_valid |-> band_lines != 5'd0 && band_lines <= 5'd16 && band_mode != 4'h1); // R7

  AST_WIDTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    pf_enable |-> pf_clocks != 8'd0); // R1

  AST_IRQ_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> line_active); // R9

endmodule

bind dl_fetcher dlf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_gnt     (mem_gnt),
  .band_valid  (band_valid),
  .band_ready  (band_ready),
  .band_mode   (band_mode),
  .band_lines  (band_lines),
  .band_hscroll(band_hscroll),
  .band_vscroll(band_vscroll),
  .band_irq    (band_irq),
  .line_active (line_active),
  .irq_pulse   (irq_pulse),
  .pf_enable   (pf_enable),
  .pf_clocks   (pf_clocks)
);

// File: tb/tb_dl_fetcher.sv
`timescale 1ns/1ps
module tb_dl_fetcher;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        line_start = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        band_valid;
  logic        band_ready = 1'b0;
  logic [3:0]  band_mode;
  logic [4:0]  band_lines;
  logic        band_hscroll, band_vscroll, band_irq;
  logic        line_active;
  logic [3:0]  line_mode;
  logic        irq_pulse;
  logic        pf_enable;
  logic [7:0]  pf_clocks;

  always #2.5 clk = ~clk;

  dl_fetcher dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .line_start(line_start),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .band_valid(band_valid), .band_ready(band_ready), .band_mode(band_mode),
    .band_lines(band_lines), .band_hscroll(band_hscroll), .band_vscroll(band_vscroll),
    .band_irq(band_irq), .line_active(line_active), .line_mode(line_mode),
    .irq_pulse(irq_pulse), .pf_enable(pf_enable), .pf_clocks(pf_clocks)
  );

  int total = 0;
  int bad = 0;
  logic [7:0]  list [32];
  logic [11:0] expq [128];
  logic [15:0] m_base = '0;
  int idx = 0, acc = 0, gcnt = 0, irq_cnt = 0, req_cnt = 0;
  int m_remain = 0;
  bit m_irq = 0;
  bit exp_pulse = 0;
  logic [3:0] cur_mode = '0;
  bit force_rdy = 1'b1;
  int wt = -1;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [4:0] ref_height(input logic [3:0] m);
    case (m)
      4'h3: return 5'd10;
      4'h5, 4'h7: return 5'd16;
      4'h9, 4'hA: return 5'd4;
      4'hB, 4'hD: return 5'd2;
      4'hC, 4'hE, 4'hF: return 5'd1;
      default: return 5'd8;
    endcase
  endfunction

  // {irq, vscroll, hscroll, lines[4:0], mode[3:0]}
  function automatic logic [11:0] ref_band(input logic [7:0] b);
    if (b[3:0] == 4'h0) return {b[7], 2'b00, 5'({2'b00, b[6:4]} + 5'd1), 4'h0};
    if (b[3:0] == 4'h1) return {b[7], 2'b00, 5'd1, 4'h0};
    return {b[7], b[5], b[4], ref_height(b[3:0]), b[3:0]};
  endfunction

  // Memory model: grants a live request after 0..3 cycles.
  always @(negedge clk) begin
    mem_gnt <= 1'b0;
    if (mem_req) begin
      if (wt < 0) wt = $urandom_range(0, 3);
      if (wt == 0) begin
        mem_gnt   <= 1'b1;
        mem_rdata <= list[5'(mem_addr - m_base)];
        chk(mem_addr == m_base + 16'(gcnt), "R4 fetch address", mem_addr, m_base + 16'(gcnt));
        gcnt++;
        wt = -1;
      end else wt--;
    end
  end

  always @(negedge clk) band_ready <= force_rdy | 1'($urandom_range(0, 1));

  // Monitor, sampled between edges.
  always @(negedge clk) begin
    #1;
    if (irq_pulse) irq_cnt++;
    if (mem_req) req_cnt++;
    if (band_valid && band_ready) begin
      chk(band_lines == expq[acc][8:4], "R7 band lines", band_lines, expq[acc][8:4]);
      chk(band_mode == expq[acc][3:0], "R6 band mode", band_mode, expq[acc][3:0]);
      chk({band_irq, band_vscroll, band_hscroll} == expq[acc][11:9], "R8 flags",
          {band_irq, band_vscroll, band_hscroll}, expq[acc][11:9]);
      acc++;
    end
  end

  task automatic cfg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_line(input bit model_on);
    @(negedge clk);
    irq_cnt = 0;
    exp_pulse = 0;
    if (model_on) begin
      if (m_remain == 0) begin
        logic [11:0] d;
        d = ref_band(list[5'(idx)]);
        expq[idx % 128] = d;
        idx++;
        m_remain = int'(d[8:4]) - 1;
        m_irq = d[11];
        exp_pulse = d[11] && (d[8:4] == 5'd1);
        cur_mode = d[3:0];
      end else begin
        m_remain--;
        exp_pulse = (m_remain == 0) && m_irq;
      end
    end
    line_start = 1'b1;
    force_rdy = 1'b0;
    @(negedge clk);
    line_start = 1'b0;
    repeat (6) @(negedge clk);
    force_rdy = 1'b1;
    repeat (14) @(negedge clk);
    #1;
    if (model_on) begin
      chk(irq_cnt == int'(exp_pulse), "R9 irq pulse count", irq_cnt, int'(exp_pulse));
      chk(line_active && line_mode == cur_mode, "R5 current band mode", line_mode, cur_mode);
      chk(!band_valid, "R10 record drained", band_valid, 0);
    end
  endtask

  task automatic run_frame(input logic [15:0] base, input int nlines, input bit alter);
    cfg(2'd1, base[7:0]);
    cfg(2'd2, base[15:8]);
    m_base = base;
    idx = 0; acc = 0; gcnt = 0; m_remain = 0; m_irq = 0;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    if (alter) begin
      cfg(2'd1, base[7:0] ^ 8'h55);
      cfg(2'd2, base[15:8] ^ 8'hA5);
    end
    for (int l = 0; l < nlines; l++) do_line(1'b1);
    chk(acc == idx, "R10 each band delivered once", acc, idx);
    chk(gcnt == idx, "R5 one fetch per band", gcnt, idx);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) list[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_req && !band_valid && !irq_pulse, "R10 reset outputs idle",
        {mem_req, band_valid, irq_pulse}, 0);
    chk(!pf_enable && pf_clocks == 8'd0, "R1 reset playfield off", pf_clocks, 0);

    // R1: width decode and enable
    for (int w = 0; w < 4; w++) begin
      cfg(2'd0, 8'h20 | 8'(w));
      #1;
      chk(pf_clocks == (w == 0 ? 8'd0 : w == 1 ? 8'd128 : w == 2 ? 8'd160 : 8'd192),
          "R1 width clocks", pf_clocks, w);
      chk(pf_enable == (w != 0), "R1 enable with width", pf_enable, w != 0);
    end
    cfg(2'd0, 8'h03);
    #1;
    chk(!pf_enable, "R1 enable needs DMA bit", pf_enable, 0);

    // R2: no fetch while disabled
    cfg(2'd1, 8'h10); cfg(2'd2, 8'h20);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    req_cnt = 0; acc = 0;
    for (int l = 0; l < 3; l++) do_line(1'b0);
    chk(req_cnt == 0, "R2 no request when disabled", req_cnt, 0);
    chk(!band_valid && acc == 0, "R2 no band when disabled", acc, 0);
    cfg(2'd0, 8'h20);
    req_cnt = 0;
    do_line(1'b0);
    chk(req_cnt == 0, "R2 zero width blocks fetch", req_cnt, 0);

    // Directed list: blank forms, every mode, flags
    cfg(2'd0, 8'h22);
    list[0] = 8'h70; list[1] = 8'h80; list[2] = 8'h81; list[3] = 8'h01;
    for (int i = 4; i < 18; i++) begin
      logic [7:0] b;
      b = 8'(i - 2);
      b[3:0] = 4'(i - 2);
      b[4] = i[0]; b[5] = i[1]; b[7] = i[2];
      list[i] = b;
    end
    for (int i = 18; i < 32; i++) list[i] = 8'h8E;
    run_frame(16'h3000, 112, 1'b0);

    // R3: pointer rewritten after frame_start is not used
    for (int i = 0; i < 32; i++) list[i] = 8'($urandom);
    run_frame(16'h1234, 40, 1'b1);

    // R4: wrap at top of address space
    for (int i = 0; i < 32; i++) list[i] = (i % 3 == 0) ? 8'h8E : 8'h0C;
    run_frame(16'hFFFA, 20, 1'b0);

    // Random frames
    for (int f = 0; f < 5; f++) begin
      cfg(2'd0, 8'h20 | 8'($urandom_range(1, 3)));
      for (int i = 0; i < 32; i++) list[i] = 8'($urandom);
      run_frame(16'($urandom), 40, 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule